// File: doc/BRIEF.md
# Iterative DES Encryption Core

This block encrypts one 64-bit block with the Data Encryption Standard. It folds all sixteen Feistel rounds onto a single round datapath and applies one round per clock. A start pulse loads the plaintext through the initial permutation into a pair of 32-bit half registers. On each of the next sixteen clock edges the round logic consumes one 48-bit subkey, which a separate key scheduler presents on the subkey input. After the last round the halves are exchanged, passed through the inverse initial permutation and latched as the ciphertext, and a one-cycle done pulse marks the result.

The key scheduler keeps the round count itself, counting from the accepted start. Because the round structure is a pure Feistel network, feeding the same subkeys in reverse order turns the core into a decryptor without any change to the hardware.

Top module: `des_iter_core`

## Requirements
- R1: While reset is held and just after it is released, `done` is 0 and `ciphertext` is all zeros.
- R2: A `start` sampled high while the core is idle is accepted. It loads the initial permutation of `plaintext`, where output bit 1 is input bit 58 and bits are numbered 1 to 64 from the MSB. `done` is high in the cycle that follows the 16th rising edge after the accepting edge.
- R3: The subkey for round k (k = 1..16) is sampled from `subkey` on the k-th rising edge after the accepting edge.
- R4: Each round sets the new left half to the old right half. The new right half is the old left half XOR f(old right, subkey). f expands with the E table (32, 1, 2, 3, 4, 5, 4, 5, ... ending in 1), XORs in the subkey, and feeds 6-bit group n (n = 1 from the MSB) to S-box n. Each S-box uses its outer bits as the row and its inner four bits as the column, and the S-box outputs go through the P permutation (16, 7, 20, 21, ...). As a result, running the core on a ciphertext with the subkeys in reverse order returns the plaintext.
- R5: The ciphertext is the inverse initial permutation of R16 followed by L16, whose first byte takes bits 40, 8, 48, 16, 56, 24, 64, 32. With key 133457799BBCDFF1 and plaintext 0123456789ABCDEF the result is 85E813540F0AB405.
- R6: `done` is high for exactly one cycle per accepted block.
- R7: `start` is ignored while a block is in progress, including on the 16th round edge. Such a pulse neither changes the result nor produces an extra `done`.
- R8: `ciphertext` holds its value in every cycle in which `done` is low.
- R9: A `start` given in the cycle in which `done` is high is accepted, so blocks can run back to back every 17 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a block, taken only when idle |
| plaintext | input | 64 | Block to encrypt, sampled with an accepted start |
| subkey | input | 48 | Round subkey, one per round edge |
| ciphertext | output | 64 | Result of the last completed block, held until the next one |
| done | output | 1 | One-cycle pulse when a new ciphertext is ready |

## Verification
The hardest case to reach from the ports is a start request that lands on the very edge where the sixteenth round retires. The control is leaving its busy state on that edge, so an off-by-one in the busy window would accept a spurious block there. The stimulus raises start, with a different plaintext, in the same cycle that presents the last subkey, and also partway through the rounds. The scoreboard then has to see exactly one correct result and no stray done. Back-to-back blocks, with start given in the done cycle, and a reverse-subkey run that must recover the plaintext cover the boundary on the other side.

// File: rtl/des_iter_pkg.sv
package des_iter_pkg;

  localparam int BLOCK_W    = 64;
  localparam int HALF_W     = BLOCK_W / 2;
  localparam int KEY_W      = 48;
  localparam int SBOX_CNT   = 8;
  localparam int SBOX_IN_W  = KEY_W / SBOX_CNT;
  localparam int SBOX_OUT_W = HALF_W / SBOX_CNT;
  localparam int SBOX_ROWS  = 4;
  localparam int SBOX_COLS  = 16;
  localparam int NUM_ROUNDS = 16;

  typedef logic [BLOCK_W-1:0] block_t;
  typedef logic [HALF_W-1:0]  half_t;
  typedef logic [KEY_W-1:0]   subkey_t;

  typedef struct packed {
    logic loadBlock;
    logic stepRound;
    logic lastRound;
  } ctrlStrobe_t;

  // P permutation sources, 1-based from the MSB
  localparam int P_SRC [HALF_W] = '{16, 7, 20, 21, 29, 12, 28, 17,
                                    1, 15, 23, 26, 5, 18, 31, 10,
                                    2, 8, 24, 14, 32, 27, 3, 9,
                                    19, 13, 30, 6, 22, 11, 4, 25};

  // Initial permutation: rows of eight, even-numbered columns first
  function automatic block_t initPerm(input block_t x);
    block_t y;
    for (int i = 0; i < BLOCK_W; i++) begin
      int row;
      int col;
      int src;
      row = i / 8;
      col = i % 8;
      src = (row < 4) ? (58 + 2 * row - 8 * col) : (57 + 2 * (row - 4) - 8 * col);
      y[BLOCK_W-1-i] = x[BLOCK_W-src];
    end
    return y;
  endfunction

  // Inverse of initPerm
  function automatic block_t finalPerm(input block_t x);
    block_t y;
    for (int i = 0; i < BLOCK_W; i++) begin
      int row;
      int col;
      int src;
      row = i / 8;
      col = i % 8;
      src = ((col % 2) == 0) ? (40 - row + 8 * (col / 2)) : (8 - row + 8 * (col / 2));
      y[BLOCK_W-1-i] = x[BLOCK_W-src];
    end
    return y;
  endfunction

  // Expansion: each 6-bit group overlaps its neighbours by one bit, wrapping
  function automatic subkey_t expandHalf(input half_t x);
    subkey_t y;
    for (int j = 0; j < KEY_W; j++) begin
      int grp;
      int pos;
      int src;
      grp = j / SBOX_IN_W;
      pos = j % SBOX_IN_W;
      src = ((4 * grp + pos + HALF_W - 1) % HALF_W) + 1;
      y[KEY_W-1-j] = x[HALF_W-src];
    end
    return y;
  endfunction

  function automatic half_t pPerm(input half_t x);
    half_t y;
    for (int i = 0; i < HALF_W; i++) begin
      y[HALF_W-1-i] = x[HALF_W-P_SRC[i]];
    end
    return y;
  endfunction

  // Each box packed row-major, entry 0 in the top nibble
  function automatic logic [255:0] sboxTable(input int box);
    case (box)
      1: return 256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D;
      2: return 256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9;
      3: return 256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C;
      4: return 256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E;
      5: return 256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453;
      6: return 256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D;
      7: return 256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C;
      8: return 256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/des_sbox.sv
module des_sbox
  import des_iter_pkg::*;
#(
  parameter int BOX_IDX = 1
) (
  input  logic [SBOX_IN_W-1:0]  sel,
  output logic [SBOX_OUT_W-1:0] val
);

  localparam logic [255:0] TABLE = sboxTable(BOX_IDX);
  localparam int           TOP   = SBOX_ROWS * SBOX_COLS * SBOX_OUT_W - 1;

  logic [5:0] entryIdx;

  // outer bits pick the row, inner four bits pick the column
  assign entryIdx = {sel[SBOX_IN_W-1], sel[0], sel[SBOX_IN_W-2:1]};

  always_comb begin
    val = TABLE[TOP - SBOX_OUT_W * int'(entryIdx) -: SBOX_OUT_W];
  end

endmodule

// File: rtl/des_feistel.sv
module des_feistel
  import des_iter_pkg::*;
(
  input  half_t   rightIn,
  input  subkey_t roundKey,
  output half_t   fOut
);

  subkey_t mixed;
  half_t   boxOut;

  assign mixed = expandHalf(rightIn) ^ roundKey;

  for (genvar g = 0; g < SBOX_CNT; g++) begin : g_box
    des_sbox #(.BOX_IDX(g + 1)) u_sbox (
      .sel (mixed[KEY_W-1-SBOX_IN_W*g -: SBOX_IN_W]),
      .val (boxOut[HALF_W-1-SBOX_OUT_W*g -: SBOX_OUT_W])
    );
  end

  assign fOut = pPerm(boxOut);

endmodule

// File: rtl/des_iter_ctrl.sv
module des_iter_ctrl
  import des_iter_pkg::*;
#(
  parameter int ROUNDS = NUM_ROUNDS,
  localparam int CNT_W = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output ctrlStrobe_t      strobe,
  output logic             done,
  output logic             busy,
  output logic [CNT_W-1:0] roundIdx
);

  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             doneQ;

  always_comb begin
    strobe.loadBlock = !busyQ && start;
    strobe.stepRound = busyQ;
    strobe.lastRound = busyQ && (cntQ == CNT_W'(ROUNDS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= strobe.lastRound;
      if (strobe.loadBlock) begin
        busyQ <= 1'b1;
        cntQ  <= '0;
      end else if (strobe.lastRound) begin
        busyQ <= 1'b0;
        cntQ  <= '0;
      end else if (busyQ) begin
        cntQ <= cntQ + CNT_W'(1);
      end
    end
  end

  assign done     = doneQ;
  assign busy     = busyQ;
  assign roundIdx = cntQ;

endmodule

// File: rtl/des_iter_datapath.sv
module des_iter_datapath
  import des_iter_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ctrlStrobe_t strobe,
  input  block_t      plainIn,
  input  subkey_t     roundKey,
  output block_t      cipherOut,
  output half_t       leftHalf,
  output half_t       rightHalf
);

  half_t  leftQ;
  half_t  rightQ;
  block_t cipherQ;
  half_t  fVal;
  half_t  leftNext;
  half_t  rightNext;
  block_t permIn;

  des_feistel u_feistel (
    .rightIn  (rightQ),
    .roundKey (roundKey),
    .fOut     (fVal)
  );

  assign permIn    = initPerm(plainIn);
  assign leftNext  = rightQ;
  assign rightNext = leftQ ^ fVal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      leftQ   <= '0;
      rightQ  <= '0;
      cipherQ <= '0;
    end else begin
      if (strobe.loadBlock) begin
        leftQ  <= permIn[BLOCK_W-1:HALF_W];
        rightQ <= permIn[HALF_W-1:0];
      end else if (strobe.stepRound) begin
        leftQ  <= leftNext;
        rightQ <= rightNext;
      end
      // halves are exchanged once after the last round
      if (strobe.lastRound) begin
        cipherQ <= finalPerm({rightNext, leftNext});
      end
    end
  end

  assign cipherOut = cipherQ;
  assign leftHalf  = leftQ;
  assign rightHalf = rightQ;

endmodule

// File: rtl/des_iter_core.sv
module des_iter_core
  import des_iter_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] plaintext,
  input  logic [47:0] subkey,
  output logic [63:0] ciphertext,
  output logic        done
);

  localparam int CNT_W = $clog2(NUM_ROUNDS);

  ctrlStrobe_t      strobe;
  logic             ctrlBusy;
  logic [CNT_W-1:0] roundIdx;
  half_t            leftHalf;
  half_t            rightHalf;

  des_iter_ctrl #(.ROUNDS(NUM_ROUNDS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .strobe   (strobe),
    .done     (done),
    .busy     (ctrlBusy),
    .roundIdx (roundIdx)
  );

  des_iter_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .plainIn   (plaintext),
    .roundKey  (subkey),
    .cipherOut (ciphertext),
    .leftHalf  (leftHalf),
    .rightHalf (rightHalf)
  );

endmodule

// File: rtl/des_iter_core_chk.sv
module des_iter_core_chk
  import des_iter_pkg::*;
#(
  parameter int ROUNDS = NUM_ROUNDS,
  localparam int CNT_W = $clog2(ROUNDS),
  localparam int MDL_W = $clog2(ROUNDS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic [63:0]      ciphertext,
  input logic             busy,
  input logic [CNT_W-1:0] roundIdx,
  input logic [31:0]      leftHalf,
  input logic [31:0]      rightHalf
);

  // port-level model of the round window
  logic [MDL_W-1:0] mdlCnt;
  logic             expDone;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdlCnt  <= '0;
      expDone <= 1'b0;
    end else begin
      expDone <= (mdlCnt == MDL_W'(1));
      if (mdlCnt == '0) begin
        if (start) mdlCnt <= MDL_W'(ROUNDS);
      end else begin
        mdlCnt <= mdlCnt - MDL_W'(1);
      end
    end
  end

  // R2, R7, R9: done appears exactly where the port model expects it
  a_r2_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done == expDone);

  // R6
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: a start while busy does not restart the round count
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && roundIdx != CNT_W'(ROUNDS - 1)) |=>
      (busy && roundIdx == $past(roundIdx) + CNT_W'(1)));

  // R4: the left half always takes the previous right half
  a_r4_left_from_right: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> leftHalf == $past(rightHalf));

  // R8
  a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ciphertext));

endmodule

bind des_iter_core des_iter_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .done       (done),
  .ciphertext (ciphertext),
  .busy       (ctrlBusy),
  .roundIdx   (roundIdx),
  .leftHalf   (leftHalf),
  .rightHalf  (rightHalf)
);

// File: tb/des_iter_core_tb.sv
module des_iter_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] plaintext = '0;
  logic [47:0] subkey = '0;
  logic [63:0] ciphertext;
  logic        done;

  always #5 clk = ~clk;

  des_iter_core u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .plaintext  (plaintext),
    .subkey     (subkey),
    .ciphertext (ciphertext),
    .done       (done)
  );

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;
  logic   prevDone = 1'b0;

  logic [63:0] expQ [$];
  longint      cycQ [$];
  string       tagQ [$];

  int PC1 [56] = '{57, 49, 41, 33, 25, 17, 9, 1, 58, 50, 42, 34, 26, 18,
                   10, 2, 59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36,
                   63, 55, 47, 39, 31, 23, 15, 7, 62, 54, 46, 38, 30, 22,
                   14, 6, 61, 53, 45, 37, 29, 21, 13, 5, 28, 20, 12, 4};
  int PC2 [48] = '{14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10,
                   23, 19, 12, 4, 26, 8, 16, 7, 27, 20, 13, 2,
                   41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
                   44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};
  int SHIFTS [16] = '{1, 1, 2, 2, 2, 2, 2, 2, 1, 2, 2, 2, 2, 2, 2, 1};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bench-side key scheduler
  function automatic logic [767:0] keySchedule(input logic [63:0] key);
    logic [767:0] all;
    logic [55:0]  cd;
    logic [27:0]  c;
    logic [27:0]  d;
    logic [47:0]  sk;
    for (int i = 0; i < 56; i++) cd[55-i] = key[64-PC1[i]];
    c = cd[55:28];
    d = cd[27:0];
    for (int r = 0; r < 16; r++) begin
      for (int s = 0; s < SHIFTS[r]; s++) begin
        c = {c[26:0], c[27]};
        d = {d[26:0], d[27]};
      end
      cd = {c, d};
      for (int j = 0; j < 48; j++) sk[47-j] = cd[56-PC2[j]];
      all[767-48*r -: 48] = sk;
    end
    return all;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prevDone) check(!done, "R6 done lasts one cycle", {63'd0, done}, 64'd0);
      if (done) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected done", ciphertext, 64'd0);
        end else begin
          logic [63:0] e;
          longint      ec;
          string       t;
          e  = expQ.pop_front();
          ec = cycQ.pop_front();
          t  = tagQ.pop_front();
          check(ciphertext == e, t, ciphertext, e);
          check(cyc == ec, "R2 done latency", 64'(cyc), 64'(ec));
        end
      end
      prevDone = done;
    end
  end

  // driver: reverse feeds subkeys 16..1, poke raises start mid-run and on the last round edge
  task automatic runOp(input logic [63:0] key, input logic [63:0] pt, input logic [63:0] exp,
                       input string tag, input bit reverse, input bit poke);
    logic [767:0] ks;
    ks = keySchedule(key);
    @(negedge clk);
    expQ.push_back(exp);
    cycQ.push_back(cyc + 17);
    tagQ.push_back(tag);
    start     = 1'b1;
    plaintext = pt;
    subkey    = '0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      start  = 1'b0;
      subkey = reverse ? ks[767-48*(15-k) -: 48] : ks[767-48*k -: 48];
      if (poke && (k == 4 || k == 15)) begin
        start     = 1'b1;
        plaintext = ~pt;
      end
    end
    if (poke) begin
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ciphertext == 64'd0, "R1 ciphertext in reset", ciphertext, 64'd0);
    check(done == 1'b0, "R1 done in reset", {63'd0, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ciphertext == 64'd0 && done == 1'b0, "R1 state after reset", ciphertext, 64'd0);

    runOp(64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 64'h85E813540F0AB405, "R5 standard vector", 1'b0, 1'b0);
    runOp(64'h133457799BBCDFF1, 64'h85E813540F0AB405, 64'h0123456789ABCDEF, "R4 R9 reversed subkeys back to back", 1'b1, 1'b0);
    runOp(64'h0000000000000000, 64'h0000000000000000, 64'h8CA64DE9C1B123A7, "R3 R4 zero key and block", 1'b0, 1'b0);
    runOp(64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'h7359B2163E4EDC58, "R3 R4 all-ones key and block", 1'b0, 1'b0);
    runOp(64'h0E329232EA6D0D73, 64'h8787878787878787, 64'h0000000000000000, "R7 start ignored while busy", 1'b0, 1'b1);
    runOp(64'h0E329232EA6D0D73, 64'h0000000000000000, 64'h8787878787878787, "R4 reversed subkeys to repeating block", 1'b1, 1'b0);

    repeat (25) @(negedge clk);
    check(expQ.size() == 0, "R9 all results delivered", 64'(expQ.size()), 64'd0);
    check(ciphertext == 64'h8787878787878787, "R8 result held while idle", ciphertext, 64'h8787878787878787);
    check(done == 1'b0, "R7 no extra done after poked block", {63'd0, done}, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule